// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a very small 8-bit processor. It connects straight to an asynchronous static RAM through one bidirectional data bus, a 6-bit address output and two active-low strobes: a read enable and a write enable. Code and data share the same 64 words of memory. The machine state is an 8-bit accumulator, a carry flag, a 6-bit program counter and a 6-bit address register. The address register drives the address pins in every cycle.

Every instruction is one byte. The upper two bits select one of four operations and the lower six bits give a memory address or a branch target. Three operations work on a memory operand: a NOR into the accumulator, an add with carry out, and a store of the accumulator. The fourth is a branch that is taken only when carry is clear, and it always leaves carry clear. Because of this, a second branch placed after any branch is unconditional.

The address path does not use the ALU. The program counter has its own incrementer. A five-state controller sequences the bus, so every instruction takes two cycles except a taken branch, which takes one.

Top module: `acc_core`

## Requirements
- R1: While reset (active low, asynchronous) is held, and before the first clock edge after release, the address output is 0, the read strobe is low and the write strobe is high, so execution starts with a fetch from word 0.
- R2: In a fetch cycle the core drives the address register onto the address pins, pulls the read strobe low and releases the data bus. The fetched byte is decoded with bits [7:6] as the opcode and bits [5:0] as the operand address or branch target. The program counter becomes the fetch address plus one.
- R3: Opcode 00 replaces the accumulator with the bitwise NOR of the accumulator and the memory operand, and leaves carry unchanged.
- R4: Opcode 01 adds the memory operand to the accumulator. Carry takes bit 8 of the 9-bit sum.
- R5: Opcode 10 takes two cycles. In its second cycle the core places the operand address on the address pins, pulls the write strobe low, keeps the read strobe high and drives the accumulator onto the data bus.
- R6: Opcode 11 with carry clear is a taken branch. In the very next cycle the core fetches from the target.
- R7: Opcode 11 with carry set is not taken. It spends one cycle with both strobes high, clears carry, and then fetches the next sequential instruction.
- R8: The two strobes are never low in the same cycle. The data bus is driven by the core only while the write strobe is low.
- R9: The core produces the greatest common divisor of two nonzero bytes when it runs a subtract-based program built from these four instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_data | inout | 8 | Shared RAM data bus |
| mem_addr | output | 6 | RAM word address |
| mem_oe_n | output | 1 | RAM read enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |

## Verification
The assertions assume that the RAM returns a defined byte whenever the read strobe is low. In a fetch they also read bits [7:6] of the bus as a real opcode. The bench keeps within this by preloading every one of the 64 words before each run and by placing data words only where they are never fetched. The random operand pairs are kept in 1 to 255, so the divisor program always reaches its final self-loop.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    typedef enum logic [2:0] {
        ST_FETCH = 3'b000,
        ST_STORE = 3'b001,
        ST_ADD   = 3'b010,
        ST_NOR   = 3'b011,
        ST_CLRC  = 3'b101
    } state_e;

    typedef enum logic [1:0] {
        OP_NOR = 2'b00,
        OP_ADD = 2'b01,
        OP_STA = 2'b10,
        OP_JCC = 2'b11
    } opcode_e;

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  state_e              state,
    input  logic [DATA_W-1:0]   acc,
    input  logic                carry,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   acc_nx,
    output logic                carry_nx
);

    logic [DATA_W:0] sum;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, operand};
        acc_nx   = acc;
        carry_nx = carry;
        unique case (state)
            ST_ADD: begin
                acc_nx   = sum[DATA_W-1:0];
                carry_nx = sum[DATA_W];
            end
            ST_NOR:  acc_nx   = ~(acc | operand);
            ST_CLRC: carry_nx = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
    import acc_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] opcode,
    input  logic       carry,
    output state_e     state_q
);

    state_e state_d;

    always_comb begin
        state_d = ST_FETCH;
        if (state_q == ST_FETCH) begin
            unique case (opcode_e'(opcode))
                OP_NOR:  state_d = ST_NOR;
                OP_ADD:  state_d = ST_ADD;
                OP_STA:  state_d = ST_STORE;
                OP_JCC:  state_d = carry ? ST_CLRC : ST_FETCH;
                default: state_d = ST_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // R2: only the five defined codes are ever held
    a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_FETCH, ST_STORE, ST_ADD, ST_NOR, ST_CLRC});

    // R6/R7: every execute state lasts one cycle and returns to fetch
    a_r7_execute_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FETCH) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/acc_core_addr.sv
module acc_core_addr
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_e            state,
    input  logic [ADDR_W-1:0] field,
    output logic [ADDR_W-1:0] adreg_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] adreg;
    } addr_regs_t;

    addr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == ST_FETCH) begin
            r_d.pc    = r_q.adreg + ADDR_W'(1);
            r_d.adreg = field;
        end else begin
            r_d.adreg = r_q.pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign adreg_q = r_q.adreg;

    // R2: a fetch advances the program counter past the fetched word
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (r_q.pc == $past(r_q.adreg) + ADDR_W'(1)));

    // R7: leaving an execute state resumes at the saved program counter
    a_r7_resume_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |=> (r_q.adreg == $past(r_q.pc)));

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int OPC_W = DATA_W - ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              carry;
    } data_regs_t;

    data_regs_t        r_d, r_q;
    state_e            state_q;
    logic [DATA_W-1:0] bus_in;
    logic [OPC_W-1:0]  opcode;
    logic [DATA_W-1:0] acc_nx;
    logic              carry_nx;
    logic              drive_bus;

    assign bus_in = mem_data;
    assign opcode = bus_in[DATA_W-1 -: OPC_W];

    acc_core_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode[1:0]),
        .carry   (r_q.carry),
        .state_q (state_q)
    );

    acc_core_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state_q),
        .field   (bus_in[ADDR_W-1:0]),
        .adreg_q (mem_addr)
    );

    acc_core_alu #(.DATA_W(DATA_W)) u_alu (
        .state    (state_q),
        .acc      (r_q.acc),
        .carry    (r_q.carry),
        .operand  (bus_in),
        .acc_nx   (acc_nx),
        .carry_nx (carry_nx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.acc   = acc_nx;
        r_d.carry = carry_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign drive_bus = (state_q == ST_STORE);
    assign mem_we_n  = !drive_bus;
    assign mem_oe_n  = !(state_q inside {ST_FETCH, ST_ADD, ST_NOR});
    assign mem_data  = drive_bus ? r_q.acc : 'z;

    // R8: read and write strobes are mutually exclusive
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R3: NOR leaves carry alone
    a_r3_nor_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOR) |=> (r_q.carry == $past(r_q.carry)));

    // R7: a branch that is not taken leaves carry clear
    a_r7_clrc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLRC) |=> !r_q.carry);

    // R6: a taken branch fetches its target on the next cycle
    a_r6_taken_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && opcode == OPC_W'(3) && !r_q.carry)
        |=> (state_q == ST_FETCH && mem_addr == $past(bus_in[ADDR_W-1:0])));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    wire  [7:0] bus;
    logic [5:0] addr;
    logic       oe_n, we_n;
    logic [7:0] ram [64];
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    int         both_low = 0;
    int         stray_drive = 0;

    always #2 clk = ~clk;

    acc_core u_acc_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_data (bus),
        .mem_addr (addr),
        .mem_oe_n (oe_n),
        .mem_we_n (we_n)
    );

    assign bus = (!oe_n && we_n) ? ram[addr] : 8'hzz;

    always @(negedge clk) begin
        if (!we_n) ram[addr] <= bus;
        if (rst_n && !oe_n && !we_n) both_low++;
        if (rst_n && we_n && oe_n && bus !== 8'hzz) stray_drive++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] enc(input logic [1:0] op, input int a);
        return {op, 6'(a)};
    endfunction

    function automatic int gcd(input int a, input int b);
        int x = a, y = b, t;
        while (y != 0) begin t = x % y; x = y; y = t; end
        return x;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_ram();
        for (int i = 0; i < 64; i++) ram[i] = 8'h00;
    endtask

    task automatic start_run();
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic run_gcd(input int a, input int b);
        bit done = 0;
        @(negedge clk) rst_n = 1'b0;
        clear_ram();
        ram[0]  = enc(2'b00, 16);  ram[1]  = enc(2'b00, 15);
        ram[2]  = enc(2'b01, 17);  ram[3]  = enc(2'b01, 14);
        ram[4]  = enc(2'b11, 9);   ram[5]  = enc(2'b10, 14);
        ram[6]  = enc(2'b01, 16);  ram[7]  = enc(2'b11, 13);
        ram[8]  = enc(2'b11, 0);   ram[9]  = enc(2'b00, 18);
        ram[10] = enc(2'b01, 17);  ram[11] = enc(2'b10, 15);
        ram[12] = enc(2'b11, 0);   ram[13] = enc(2'b11, 13);
        ram[14] = 8'(a); ram[15] = 8'(b);
        ram[16] = 8'hFF; ram[17] = 8'h01; ram[18] = 8'h00;
        start_run();
        for (int i = 0; i < 20000 && !done; i++) begin
            step(1);
            if (addr == 6'd13 && !oe_n) done = 1;
        end
        step(3);
        // R9: result left in the second operand word
        check($sformatf("R9 gcd(%0d,%0d)", a, b), done ? int'(ram[15]) : -1, gcd(a, b));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0C0E);

        // Directed timing program
        clear_ram();
        ram[0]  = enc(2'b11, 5);
        ram[5]  = enc(2'b01, 20);
        ram[6]  = enc(2'b01, 20);
        ram[7]  = enc(2'b00, 22);
        ram[8]  = enc(2'b11, 0);
        ram[9]  = enc(2'b10, 21);
        ram[10] = enc(2'b11, 10);
        ram[20] = 8'h80;
        ram[22] = 8'h0F;
        step(2);
        // R1: reset state
        check("R1 addr in reset", addr, 0);
        check("R1 oe_n in reset", oe_n, 0);
        check("R1 we_n in reset", we_n, 1);
        rst_n = 1'b1;
        check("R1 addr after release", addr, 0);
        step(1);
        check("R6 taken branch target", addr, 5);
        check("R2 fetch reads", oe_n, 0);
        step(1);
        check("R2 operand address", addr, 20);
        step(1);
        check("R2 next sequential", addr, 6);
        step(3);
        check("R3 nor operand address", addr, 22);
        step(1);
        check("R7 branch fetch", addr, 8);
        step(1);
        check("R7 no strobe oe_n", oe_n, 1);
        check("R7 no strobe we_n", we_n, 1);
        step(1);
        // R4 carry from 80+80 makes this branch fall through
        check("R4 R7 fall through", addr, 9);
        step(1);
        check("R5 store address", addr, 21);
        check("R5 store we_n", we_n, 0);
        check("R5 store oe_n", oe_n, 1);
        check("R5 R8 store data", bus, 8'hF0);
        step(1);
        check("R7 resume after store", addr, 10);
        step(1);
        check("R6 self loop", addr, 10);
        check("R3 R4 stored result", ram[21], 8'hF0);

        // Program-level runs
        run_gcd(12, 18);
        run_gcd(77, 77);
        run_gcd(255, 1);
        run_gcd(1, 200);
        run_gcd(128, 96);
        for (int k = 0; k < 6; k++)
            run_gcd(int'($urandom_range(255, 1)), int'($urandom_range(255, 1)));

        check("R8 strobes never both low", both_low, 0);
        check("R8 bus idle without write", stray_drive, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule